// File: doc/BRIEF.md
# Programmable Memory-Timing Microsequencer

This block produces the control strobes for an external memory from short microprograms that software stores in a 64-word internal array. Each 32-bit array word describes one clock of a bus cycle. Its low byte holds four strobe levels, a two-bit address-multiplex select, an acknowledge bit and an end-of-pattern bit. When a local-bus access hits the block's chip select, the sequencer steps through the words, one per clock, until it has shown a word that has its end bit set.

Software reaches the block through two registers: a mode register and a data register. The mode register holds a two-bit operation code and a six-bit array pointer. The data register holds the word to be stored, or the word last fetched. The array is loaded and inspected with dummy accesses that hit the chip select while the operation code selects array-write or array-read. The pointer steps after each such access. If the bus monitor times out during a pattern, the pattern is dropped and a fixed recovery pattern releases the strobes in an orderly way.

Top module: `tseq_top`

## Requirements
- R1: After reset, mem_strb is all ones and ale, ad_oe, ta and busy are 0. The mode register reads 0 and the data register reads 0.
- R2: With op code 01 (mode bits [7:6]), a chip-select write access stores the data register into the array word at the pointer (mode bits [5:0]). No strobe, ale, ad_oe or busy activity occurs during this access.
- R3: With op code 10, a chip-select read access copies the array word at the pointer into the data register.
- R4: The pointer increases by one, modulo 64, in the clock after each accepted dummy access. This lets software see that the access has finished.
- R5: With op code 00, a read access runs the pattern from word 0 and a write access runs it from word 16. The sequencer shows one word per clock. Word bits [3:0] go to mem_strb and busy is high. The sequencer returns to idle after showing a word with bit 7 set.
- R6: ta follows word bit 6 in patterns started by an op-00 access. ta is 0 throughout run-mode and recovery patterns.
- R7: ale pulses on the first word of an op-00 pattern. In every pattern, ale also pulses on any word whose multiplex select (bits [5:4]) differs from the previous word's select.
- R8: ad_oe is high for every word of an op-00 pattern. In a run-mode pattern, ad_oe stays low until the first ale and is high from then on.
- R9: With op code 11, any chip-select access runs the pattern starting at the pointer.
- R10: If bus_timeout is high during a pattern, the next clock shows word 60, and the recovery pattern then runs to its end bit. bus_timeout has no effect while idle or during recovery.
- R11: A register write that arrives while a dummy access is pending is held. It takes effect only after that access completes, so the access uses the old values.
- R12: A request without req_cs_hit starts nothing and leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the mode register, 1 selects the data register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| req_valid | input | 1 | Local-bus access request |
| req_write | input | 1 | Access direction, 1 for write |
| req_cs_hit | input | 1 | Access hits this block's chip select |
| bus_timeout | input | 1 | Bus-monitor expiry |
| mem_strb | output | 4 | Memory control strobe levels |
| ale | output | 1 | Address-latch-enable strobe |
| ad_oe | output | 1 | Address/data bus drive enable, 0 means high-impedance |
| ta | output | 1 | Transfer acknowledge to the requester |
| busy | output | 1 | A pattern is executing |

## Verification
The bench first fills the array with dummy writes, some at consecutive addresses and some after a pointer reload, and reads every word back. This separates a wrong store from a wrong pointer step. Four patterns are then compared clock by clock: normal read, normal write, run mode and a timeout. The run-mode words carry acknowledge bits and an unchanged first select, which tells ta suppression and delayed bus drive apart from the normal rules. The timeout case shows whether the jump lands on the recovery word at the right clock. Further directed cases cover a register write that races a dummy access, pointer wrap, a chip-select miss and a timeout while idle.

// File: rtl/tseq_pkg.sv
`timescale 1ns/1ps
// Package: shared word layout and op codes of the microsequencer.
// Assumes a 32-bit array word; only the low byte carries decoded fields.
package tseq_pkg;
    localparam int WORD_W = 32;
    localparam int STRB_W = 4;
    localparam int AMX_W  = 2;

    typedef enum logic [1:0] {
        OP_NORM   = 2'b00,
        OP_ARR_WR = 2'b01,
        OP_ARR_RD = 2'b10,
        OP_RUN    = 2'b11
    } op_e;

    typedef struct packed {
        logic [WORD_W-STRB_W-AMX_W-3:0] spare;
        logic                           last;
        logic                           ack;
        logic [AMX_W-1:0]               amx;
        logic [STRB_W-1:0]              strb;
    } uword_t;
endpackage

// File: rtl/tseq_array.sv
`timescale 1ns/1ps
// Module: microinstruction store with one write port and two asynchronous
// read ports (one for the pattern engine, one for debug readback).
// Assumes a depth small enough for a register-based implementation.
module tseq_array
    import tseq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr_a,
    output logic [WORD_W-1:0] rd_data_a,
    input  logic [AW-1:0]     rd_addr_b,
    output logic [WORD_W-1:0] rd_data_b
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Purpose: clear the store on reset, otherwise accept one word per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Purpose: combinational reads for both consumers.
    always_comb begin
        rd_data_a = mem[rd_addr_a];
        rd_data_b = mem[rd_addr_b];
    end
endmodule

// File: rtl/tseq_regs.sv
`timescale 1ns/1ps
// Module: mode and data registers with a one-deep held-write slot.
// Assumes hold covers every cycle from acceptance to completion of a dummy
// access; a write seen during hold is parked and applied once hold drops.
module tseq_regs
    import tseq_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              hold,
    input  logic              dummy_fire,
    input  logic              dummy_is_wr,
    input  logic [WORD_W-1:0] arr_rdata,
    output op_e               op,
    output logic [AW-1:0]     ptr,
    output logic [WORD_W-1:0] data_q,
    output logic              pend_valid
);
    localparam int MODE_W = AW + 2;

    op_e               op_q;
    logic [AW-1:0]     ptr_q;
    logic              pend_sel;
    logic [WORD_W-1:0] pend_data;

    // Purpose: dummy side effects first, then the parked write, then a direct write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= OP_NORM;
            ptr_q      <= '0;
            data_q     <= '0;
            pend_valid <= 1'b0;
            pend_sel   <= 1'b0;
            pend_data  <= '0;
        end else begin
            if (dummy_fire) begin
                ptr_q <= ptr_q + 1'b1;
                if (!dummy_is_wr) data_q <= arr_rdata;
            end
            if (pend_valid && !hold) begin
                pend_valid <= 1'b0;
                if (pend_sel) begin
                    data_q <= pend_data;
                end else begin
                    op_q  <= op_e'(pend_data[AW+1:AW]);
                    ptr_q <= pend_data[AW-1:0];
                end
            end
            if (reg_wr) begin
                if (hold) begin
                    pend_valid <= 1'b1;
                    pend_sel   <= reg_sel;
                    pend_data  <= reg_wdata;
                end else if (reg_sel) begin
                    data_q <= reg_wdata;
                end else begin
                    op_q  <= op_e'(reg_wdata[AW+1:AW]);
                    ptr_q <= reg_wdata[AW-1:0];
                end
            end
        end
    end

    // Purpose: expose the current fields and the selected register for readback.
    always_comb begin
        op        = op_q;
        ptr       = ptr_q;
        reg_rdata = reg_sel ? data_q : WORD_W'({op_q, ptr_q});
    end

    logic [MODE_W-1:0] unused_mode;
    assign unused_mode = {op_q, ptr_q};
endmodule

// File: rtl/tseq_engine.sv
`timescale 1ns/1ps
// Module: request acceptance, dummy-access control and pattern stepping.
// Assumes word fields as defined in tseq_pkg and that the array read of the
// program counter is combinational. One word is shown per clock.
module tseq_engine
    import tseq_pkg::*;
#(
    parameter int AW       = 6,
    parameter int RD_BASE  = 0,
    parameter int WR_BASE  = 16,
    parameter int EXC_BASE = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_cs_hit,
    input  logic              bus_timeout,
    input  op_e               op,
    input  logic [AW-1:0]     ptr,
    input  logic              pend_valid,
    input  uword_t            word,
    output logic [AW-1:0]     pc,
    output logic              dummy_fire,
    output logic              dummy_is_wr,
    output logic              hold,
    output logic [STRB_W-1:0] mem_strb,
    output logic              ale,
    output logic              ad_oe,
    output logic              ta,
    output logic              busy,
    output logic              run_sw,
    output logic              exc_active
);
    typedef enum logic [1:0] {S_IDLE, S_DUMMY, S_RUN} state_e;

    state_e           state;
    logic             first;
    logic             ale_seen;
    logic [AMX_W-1:0] prev_amx;
    logic             start, start_dummy, start_pat, running, amx_chg;

    // Purpose: decide whether a request is accepted and what it starts.
    always_comb begin
        start       = (state == S_IDLE) && req_valid && req_cs_hit && !pend_valid;
        start_dummy = start && (((op == OP_ARR_WR) && req_write) ||
                                ((op == OP_ARR_RD) && !req_write));
        start_pat   = start && ((op == OP_NORM) || (op == OP_RUN));
        hold        = (state == S_DUMMY) || start_dummy;
        dummy_fire  = (state == S_DUMMY);
    end

    // Purpose: sequencer state, program counter and per-pattern flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            pc          <= '0;
            run_sw      <= 1'b0;
            exc_active  <= 1'b0;
            first       <= 1'b0;
            ale_seen    <= 1'b0;
            prev_amx    <= '0;
            dummy_is_wr <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start_dummy) begin
                        state       <= S_DUMMY;
                        dummy_is_wr <= req_write;
                    end else if (start_pat) begin
                        state      <= S_RUN;
                        run_sw     <= (op == OP_RUN);
                        exc_active <= 1'b0;
                        first      <= 1'b1;
                        ale_seen   <= 1'b0;
                        if (op == OP_RUN)  pc <= ptr;
                        else if (req_write) pc <= AW'(WR_BASE);
                        else               pc <= AW'(RD_BASE);
                    end
                end
                S_DUMMY: state <= S_IDLE;
                S_RUN: begin
                    first    <= 1'b0;
                    prev_amx <= word.amx;
                    if (ale) ale_seen <= 1'b1;
                    if (bus_timeout && !exc_active) begin
                        pc         <= AW'(EXC_BASE);
                        exc_active <= 1'b1;
                    end else if (word.last) begin
                        state <= S_IDLE;
                    end else begin
                        pc <= pc + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Purpose: map the current word onto the memory-side outputs.
    always_comb begin
        running  = (state == S_RUN);
        amx_chg  = !first && (word.amx != prev_amx);
        ale      = running && (amx_chg || (first && !run_sw));
        ad_oe    = running && (!run_sw || ale_seen || ale);
        ta       = running && !run_sw && !exc_active && word.ack;
        mem_strb = running ? word.strb : '1;
        busy     = running;
    end
endmodule

// File: rtl/tseq_top.sv
`timescale 1ns/1ps
// Module: top of the memory-timing microsequencer. Ties together the word
// store, the software registers and the pattern engine. Assumes requests are
// held by the requester only for the clock in which they are presented.
module tseq_top
    import tseq_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int RD_BASE  = 0,
    parameter int WR_BASE  = 16,
    parameter int EXC_BASE = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_cs_hit,
    input  logic              bus_timeout,
    output logic [3:0]        mem_strb,
    output logic              ale,
    output logic              ad_oe,
    output logic              ta,
    output logic              busy
);
    localparam int AW = $clog2(DEPTH);

    op_e               op;
    logic [AW-1:0]     ptr, pc;
    logic [WORD_W-1:0] data_q, word_raw, rb_word;
    logic              pend_valid, hold, dummy_fire, dummy_is_wr;
    logic              run_sw, exc_active;
    uword_t            cur_word;

    assign cur_word = uword_t'(word_raw);

    tseq_array #(.DEPTH(DEPTH), .AW(AW)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (dummy_fire && dummy_is_wr),
        .wr_addr   (ptr),
        .wr_data   (data_q),
        .rd_addr_a (pc),
        .rd_data_a (word_raw),
        .rd_addr_b (ptr),
        .rd_data_b (rb_word)
    );

    tseq_regs #(.AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .hold        (hold),
        .dummy_fire  (dummy_fire),
        .dummy_is_wr (dummy_is_wr),
        .arr_rdata   (rb_word),
        .op          (op),
        .ptr         (ptr),
        .data_q      (data_q),
        .pend_valid  (pend_valid)
    );

    tseq_engine #(.AW(AW), .RD_BASE(RD_BASE), .WR_BASE(WR_BASE),
                  .EXC_BASE(EXC_BASE)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_cs_hit  (req_cs_hit),
        .bus_timeout (bus_timeout),
        .op          (op),
        .ptr         (ptr),
        .pend_valid  (pend_valid),
        .word        (cur_word),
        .pc          (pc),
        .dummy_fire  (dummy_fire),
        .dummy_is_wr (dummy_is_wr),
        .hold        (hold),
        .mem_strb    (mem_strb),
        .ale         (ale),
        .ad_oe       (ad_oe),
        .ta          (ta),
        .busy        (busy),
        .run_sw      (run_sw),
        .exc_active  (exc_active)
    );
endmodule

// File: rtl/tseq_chk.sv
`timescale 1ns/1ps
// Module: property checker for tseq_top, attached by bind.
// Assumes it sees the top's internal pointer, program counter and flags.
module tseq_chk #(
    parameter int AW       = 6,
    parameter int EXC_BASE = 60
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    mem_strb,
    input logic          ale,
    input logic          ad_oe,
    input logic          ta,
    input logic          busy,
    input logic          bus_timeout,
    input logic          dummy_fire,
    input logic [AW-1:0] ptr,
    input logic [AW-1:0] pc,
    input logic          run_sw,
    input logic          exc_active,
    input logic          cur_last
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_strb == 4'hF && !ale && !ad_oe && !ta));

    assert_dummy_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dummy_fire |-> !busy);

    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dummy_fire |=> (ptr == AW'($past(ptr) + 1'b1)));

    assert_last_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cur_last && !(bus_timeout && !exc_active)) |=> !busy);

    assert_sw_no_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_sw || exc_active) |-> !ta);

    assert_ale_drives_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ad_oe);

    assert_exc_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_timeout && !exc_active) |=>
            (busy && exc_active && pc == AW'(EXC_BASE)));
endmodule

bind tseq_top tseq_chk #(.AW(AW), .EXC_BASE(EXC_BASE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_strb    (mem_strb),
    .ale         (ale),
    .ad_oe       (ad_oe),
    .ta          (ta),
    .busy        (busy),
    .bus_timeout (bus_timeout),
    .dummy_fire  (dummy_fire),
    .ptr         (ptr),
    .pc          (pc),
    .run_sw      (run_sw),
    .exc_active  (exc_active),
    .cur_last    (cur_word.last)
);

// File: tb/sim_tseq_top.sv
`timescale 1ns/1ps
module sim_tseq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        req_valid = 1'b0, req_write = 1'b0, req_cs_hit = 1'b0;
    logic        bus_timeout = 1'b0;
    logic [3:0]  mem_strb;
    logic        ale, ad_oe, ta, busy;

    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    tseq_top u0 (.*);

    // Program table: {address, word}. Word low byte: [3:0] strb, [5:4] select,
    // [6] acknowledge, [7] end of pattern.
    localparam logic [37:0] PROG [10] = '{
        {6'd0,  32'h0100_000E}, {6'd1,  32'h0200_001C}, {6'd2,  32'h0300_00DD},
        {6'd16, 32'h0400_000B}, {6'd17, 32'h0500_00E3},
        {6'd32, 32'h0600_0047}, {6'd33, 32'h0700_0036}, {6'd34, 32'h0800_00F7},
        {6'd60, 32'h0900_000C}, {6'd61, 32'h0A00_008F}
    };

    // Expected per clock: {mem_strb, ale, ad_oe, ta, busy}.
    // read 0..3, write 4..6, run 7..10, timeout 11..14
    localparam logic [7:0] WAVE [15] = '{
        8'hED, 8'hCD, 8'hD7, 8'hF0,
        8'hBD, 8'h3F, 8'hF0,
        8'h71, 8'h6D, 8'h75, 8'hF0,
        8'hED, 8'hC5, 8'hF5, 8'hF0
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic sel, input logic [31:0] val);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic sel, output logic [31:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic dummy(input logic wr);
        req_valid = 1'b1; req_write = wr; req_cs_hit = 1'b1;
        tick();
        req_valid = 1'b0;
        tick();
        tick();
    endtask

    task automatic run_scn(input string req, input logic wr, input int start,
                           input int len, input int to_at);
        req_valid = 1'b1; req_write = wr; req_cs_hit = 1'b1;
        tick();
        req_valid = 1'b0;
        for (int i = 0; i < len; i++) begin
            chk(req, {24'h0, mem_strb, ale, ad_oe, ta, busy}, {24'h0, WAVE[start+i]});
            bus_timeout = (i == to_at);
            tick();
            bus_timeout = 1'b0;
        end
    endtask

    initial begin
        logic [31:0] v;
        logic [5:0]  cur;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 outputs", {24'h0, mem_strb, ale, ad_oe, ta, busy}, 32'hF0);
        rd_reg(1'b0, v); chk("R1 mode", v, 32'h0);
        rd_reg(1'b1, v); chk("R1 data", v, 32'h0);

        // R2/R4 programming loop with pointer reloads only on gaps
        cur = 6'd0;
        wr_reg(1'b0, 32'h40);
        for (int i = 0; i < 10; i++) begin
            if (PROG[i][37:32] != cur) wr_reg(1'b0, {24'h0, 2'b01, PROG[i][37:32]});
            wr_reg(1'b1, PROG[i][31:0]);
            req_valid = 1'b1; req_write = 1'b1; req_cs_hit = 1'b1;
            tick();
            req_valid = 1'b0;
            chk("R2 no strobe during dummy", {24'h0, mem_strb, ale, ad_oe, ta, busy}, 32'hF0);
            tick(); tick();
            cur = PROG[i][37:32] + 6'd1;
        end
        rd_reg(1'b0, v); chk("R4 pointer after program", v, {24'h0, 2'b01, 6'd62});

        // R3 readback loop
        for (int i = 0; i < 10; i++) begin
            wr_reg(1'b0, {24'h0, 2'b10, PROG[i][37:32]});
            dummy(1'b0);
            rd_reg(1'b1, v); chk("R3 readback", v, PROG[i][31:0]);
        end

        // R4 wrap
        wr_reg(1'b0, {24'h0, 2'b10, 6'd63});
        dummy(1'b0);
        rd_reg(1'b0, v); chk("R4 wrap", v, {24'h0, 2'b10, 6'd0});

        // R5 R6 R7 R8 normal read and write
        wr_reg(1'b0, 32'h00);
        run_scn("R5 R7 R8 read pattern", 1'b0, 0, 4, -1);
        run_scn("R5 R6 write pattern", 1'b1, 4, 3, -1);

        // R9 R6 R8 run mode from pointer 32
        wr_reg(1'b0, {24'h0, 2'b11, 6'd32});
        run_scn("R9 R6 R8 run pattern", 1'b0, 7, 4, -1);

        // R10 timeout during normal read
        wr_reg(1'b0, 32'h00);
        run_scn("R10 timeout pattern", 1'b0, 11, 4, 0);

        // R10 timeout while idle ignored
        bus_timeout = 1'b1; tick(); bus_timeout = 1'b0;
        chk("R10 idle timeout", {24'h0, mem_strb, ale, ad_oe, ta, busy}, 32'hF0);

        // R12 chip-select miss
        wr_reg(1'b0, {24'h0, 2'b01, 6'd50});
        wr_reg(1'b1, 32'hDEAD_BEEF);
        req_valid = 1'b1; req_write = 1'b1; req_cs_hit = 1'b0;
        tick(); req_valid = 1'b0; tick(); tick();
        chk("R12 busy", {31'h0, busy}, 32'h0);
        rd_reg(1'b0, v); chk("R12 pointer", v, {24'h0, 2'b01, 6'd50});

        // R11 write racing a dummy write
        wr_reg(1'b0, {24'h0, 2'b01, 6'd40});
        wr_reg(1'b1, 32'h0000_00A5);
        req_valid = 1'b1; req_write = 1'b1; req_cs_hit = 1'b1;
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h0000_005A;
        tick();
        req_valid = 1'b0; reg_wr = 1'b0;
        tick();
        rd_reg(1'b1, v); chk("R11 held until completion", v, 32'hA5);
        tick();
        rd_reg(1'b1, v); chk("R11 applied after", v, 32'h5A);
        rd_reg(1'b0, v); chk("R11 R4 pointer", v, {24'h0, 2'b01, 6'd41});
        wr_reg(1'b0, {24'h0, 2'b10, 6'd40});
        dummy(1'b0);
        rd_reg(1'b1, v); chk("R11 stored old data", v, 32'hA5);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #800000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule